// File: doc/BRIEF.md
# Reset and Boot Start Sequencer

This block decides how a small processor core leaves reset. It watches an active-low reset pin through a two-flop synchroniser, a mode strap that enables or skips booting, a bus-request line from an external master, and a done pulse from the boot loader. From these it drives a core hold, a stack-pointer clear, an interrupt mask, a status-register clear, a one-cycle boot-loader start, and a one-cycle fetch start that carries the first program address.

A separate active-low power-on input resets the sequencer itself and arms a one-bit cold flag. While that flag is set, the core stays held until a lock counter has run down, which gives the clock generator time to settle. A later reset on the pin skips that wait because the clock never stopped. Instead, the pin must stay low for a minimum number of clocks, and shorter glitches are ignored. When reset ends, a pending bus request parks the sequencer until the request drops. Then the strap picks either a boot-load pass, which finishes on the loader's done pulse, or a direct start. In both cases execution begins with a fetch at the reset vector, which is 0 by default.

Top module: `rst_boot_seq`

## Requirements
- R1: While in reset (power-on input low, or after an accepted pin reset), `core_hold_o`, `stack_clr_o`, `irq_mask_o` and `status_clr_o` are all 1, and `boot_start_o` and `fetch_go_o` are 0.
- R2: After the power-on input rises, the core stays held for at least LOCK_CYCLES clocks, even when the reset pin is inactive. It is released no later than LOCK_CYCLES+4 clocks.
- R3: After an accepted pin reset, release comes within 5 clocks of the pin going high, with no lock wait. Only the power-on input re-arms the lock wait.
- R4: While the core is out of reset, a low pulse on `rst_pin_n_i` shorter than MIN_PULSE clocks has no effect: `core_hold_o` stays 0 and no start pulse appears.
- R5: A low level on `rst_pin_n_i` that lasts at least MIN_PULSE clocks puts the block back into reset from any state outside reset.
- R6: On release with `mode_strap_i`=0 and `bus_req_i`=0, `boot_start_o` pulses for exactly one clock. The core stays held until `boot_done_i` is seen.
- R7: On release with `mode_strap_i`=1 and no bus request, no boot start occurs and the core starts directly.
- R8: If `bus_req_i` is 1 at release, the core stays held and neither start pulse appears until `bus_req_i` is 0. The R6/R7 choice is then made from the strap value at that moment.
- R9: Entering execution gives a single-cycle `fetch_go_o`. In that same cycle `core_hold_o` falls, and `fetch_addr_o` equals RESET_VECTOR (0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| por_n_i | input | 1 | Power-on reset, active low; resets the sequencer and arms the cold flag |
| rst_pin_n_i | input | 1 | Asynchronous reset pin, active low |
| mode_strap_i | input | 1 | 0 = boot-load on release, 1 = start directly |
| bus_req_i | input | 1 | External bus request pending |
| boot_done_i | input | 1 | Single-cycle completion pulse from the boot loader |
| core_hold_o | output | 1 | Holds the core pipeline |
| stack_clr_o | output | 1 | Forces stack pointers to empty |
| irq_mask_o | output | 1 | Masks all interrupts |
| status_clr_o | output | 1 | Clears the mode/status register |
| boot_start_o | output | 1 | Single-cycle start pulse to the boot loader |
| fetch_go_o | output | 1 | Single-cycle first-fetch strobe |
| fetch_addr_o | output | ADDR_W | First fetch address |

## Verification
The assertions assume three things about the inputs. `boot_done_i` pulses only while a boot pass is under way. `mode_strap_i` and `bus_req_i` are sampled in the clock domain, so the boot-cause check may look one cycle back at them. The power-on input is the only source of the cold flag. The stimulus follows these rules: it changes every input on the falling clock edge, raises `boot_done_i` only after it has seen a boot start, and changes the strap only while the core is held. The pin pulses are sized to land just below and at the filter threshold, because the pulse-width checks depend on that boundary.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    typedef enum logic [1:0] {
        SQ_RESET   = 2'd0,
        SQ_BUSWAIT = 2'd1,
        SQ_BOOT    = 2'd2,
        SQ_RUN     = 2'd3
    } seq_state_e;
endpackage

// File: rtl/rbs_sync.sv
module rbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n_i,
    input  logic pin_n_i,
    output logic rst_act_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], pin_n_i};
    end

    always_ff @(posedge clk or negedge por_n_i) begin
        if (!por_n_i) sync_q <= '0;
        else          sync_q <= sync_d;
    end

    assign rst_act_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/rbs_width_filter.sv
module rbs_width_filter #(
    parameter int MIN_PULSE = 8
) (
    input  logic clk,
    input  logic por_n_i,
    input  logic arm_i,
    input  logic rst_act_i,
    output logic hit_o
);
    localparam int CW = $clog2(MIN_PULSE + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        hit_o = arm_i && rst_act_i && (cur_q.cnt == CW'(MIN_PULSE - 1));
        if (!arm_i || !rst_act_i || hit_o) nxt_d.cnt = '0;
        else                               nxt_d.cnt = cur_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge por_n_i) begin
        if (!por_n_i) cur_q <= '0;
        else          cur_q <= nxt_d;
    end

    // R5: a hit is only ever preceded by an asserted reset level
    p_hit_needs_level_r5: assert property (@(posedge clk) disable iff (!por_n_i)
        hit_o |-> (rst_act_i && $past(rst_act_i) || MIN_PULSE < 2))
        else $error("p_hit_needs_level_r5");
endmodule

// File: rtl/rst_boot_seq.sv
module rst_boot_seq #(
    parameter int          LOCK_CYCLES  = 2000,
    parameter int          MIN_PULSE    = 8,
    parameter int          ADDR_W       = 14,
    parameter logic [13:0] RESET_VECTOR = 14'h0000
) (
    input  logic              clk,
    input  logic              por_n_i,
    input  logic              rst_pin_n_i,
    input  logic              mode_strap_i,
    input  logic              bus_req_i,
    input  logic              boot_done_i,
    output logic              core_hold_o,
    output logic              stack_clr_o,
    output logic              irq_mask_o,
    output logic              status_clr_o,
    output logic              boot_start_o,
    output logic              fetch_go_o,
    output logic [ADDR_W-1:0] fetch_addr_o
);
    import rbs_pkg::*;

    localparam int LW = $clog2(LOCK_CYCLES + 1);

    typedef struct packed {
        seq_state_e    state;
        logic          cold;
        logic [LW-1:0] lock_cnt;
        logic          boot_go;
        logic          fetch_go;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic rst_act;
    logic warm_hit;
    logic decide;

    rbs_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .por_n_i   (por_n_i),
        .pin_n_i   (rst_pin_n_i),
        .rst_act_o (rst_act)
    );

    rbs_width_filter #(.MIN_PULSE(MIN_PULSE)) u_filter (
        .clk       (clk),
        .por_n_i   (por_n_i),
        .arm_i     (cur_q.state != SQ_RESET),
        .rst_act_i (rst_act),
        .hit_o     (warm_hit)
    );

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.boot_go  = 1'b0;
        nxt_d.fetch_go = 1'b0;
        decide         = 1'b0;
        unique case (cur_q.state)
            SQ_RESET: begin
                if (cur_q.cold && cur_q.lock_cnt != '0)
                    nxt_d.lock_cnt = cur_q.lock_cnt - LW'(1);
                if (!rst_act && (!cur_q.cold || cur_q.lock_cnt == '0)) begin
                    nxt_d.cold = 1'b0;
                    decide     = 1'b1;
                end
            end
            SQ_BUSWAIT: decide = 1'b1;
            SQ_BOOT: begin
                if (boot_done_i) begin
                    nxt_d.state    = SQ_RUN;
                    nxt_d.fetch_go = 1'b1;
                end
            end
            default: ;
        endcase
        if (decide) begin
            if (bus_req_i) begin
                nxt_d.state = SQ_BUSWAIT;
            end else if (!mode_strap_i) begin
                nxt_d.state   = SQ_BOOT;
                nxt_d.boot_go = 1'b1;
            end else begin
                nxt_d.state    = SQ_RUN;
                nxt_d.fetch_go = 1'b1;
            end
        end
        if (warm_hit) begin
            nxt_d.state    = SQ_RESET;
            nxt_d.boot_go  = 1'b0;
            nxt_d.fetch_go = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n_i) begin
        if (!por_n_i) begin
            cur_q.state    <= SQ_RESET;
            cur_q.cold     <= 1'b1;
            cur_q.lock_cnt <= LW'(LOCK_CYCLES);
            cur_q.boot_go  <= 1'b0;
            cur_q.fetch_go <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign core_hold_o  = (cur_q.state != SQ_RUN);
    assign irq_mask_o   = (cur_q.state != SQ_RUN);
    assign stack_clr_o  = (cur_q.state == SQ_RESET);
    assign status_clr_o = (cur_q.state == SQ_RESET);
    assign boot_start_o = cur_q.boot_go;
    assign fetch_go_o   = cur_q.fetch_go;
    assign fetch_addr_o = ADDR_W'(RESET_VECTOR);

    // R2: core held while the cold lock count has not run out
    p_cold_lock_r2: assert property (@(posedge clk) disable iff (!por_n_i)
        (cur_q.cold && cur_q.lock_cnt != '0) |-> core_hold_o)
        else $error("p_cold_lock_r2");

    // R6: boot start lasts one cycle
    p_boot_one_shot_r6: assert property (@(posedge clk) disable iff (!por_n_i)
        boot_start_o |=> !boot_start_o)
        else $error("p_boot_one_shot_r6");

    // R7: a boot start is caused only by strap 0 with no bus request
    p_boot_cause_r7: assert property (@(posedge clk) disable iff (!por_n_i)
        boot_start_o |-> ($past(!mode_strap_i) && $past(!bus_req_i)))
        else $error("p_boot_cause_r7");

    // R8: a pending request in the wait state holds the core
    p_bus_wait_r8: assert property (@(posedge clk) disable iff (!por_n_i)
        (cur_q.state == SQ_BUSWAIT && bus_req_i && !warm_hit) |=> (core_hold_o && !fetch_go_o && !boot_start_o))
        else $error("p_bus_wait_r8");

    // R9: first fetch strobe comes with release from hold, once
    p_fetch_release_r9: assert property (@(posedge clk) disable iff (!por_n_i)
        fetch_go_o |-> (!core_hold_o && $past(core_hold_o)))
        else $error("p_fetch_release_r9");
endmodule

// File: tb/rst_boot_seq_tb.sv
module rst_boot_seq_tb;
    localparam int LOCK = 2000;
    localparam int MINP = 8;

    logic clk = 1'b0;
    logic por_n = 1'b0, pin_n = 1'b1, strap = 1'b1, breq = 1'b0, bdone = 1'b0;
    logic hold, sclr, imask, stclr, bstart, fgo;
    logic [13:0] faddr;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    int exp_q[$];   // 1 = boot start, 2 = fetch start

    always #10 clk = ~clk;

    rst_boot_seq #(.LOCK_CYCLES(LOCK), .MIN_PULSE(MINP)) u_dut (
        .clk(clk), .por_n_i(por_n), .rst_pin_n_i(pin_n), .mode_strap_i(strap),
        .bus_req_i(breq), .boot_done_i(bdone), .core_hold_o(hold), .stack_clr_o(sclr),
        .irq_mask_o(imask), .status_clr_o(stclr), .boot_start_o(bstart),
        .fetch_go_o(fgo), .fetch_addr_o(faddr));

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (por_n && (bstart || fgo)) begin
            int got;
            got = bstart ? 1 : 2;
            if (exp_q.size() == 0) begin
                chk(1'b0, got == 1 ? "R6" : "R9", "unexpected start pulse", got, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(got == e, "R7", "start pulse kind", got, e);
                if (got == 2) begin
                    chk(faddr == 14'h0 && !hold, "R9", "fetch address/hold at fetch", int'(faddr), 0);
                end else begin
                    chk(hold, "R6", "hold during boot start", hold, 1);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_pulse(input int n);
        pin_n = 1'b0;
        cyc(n);
        pin_n = 1'b1;
    endtask

    task automatic wait_release(output int n);
        n = 0;
        while (hold && n < LOCK + 50) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic warm_reset(output int rel);
        bit seen_hold, seen_clr;
        seen_hold = 0; seen_clr = 0;
        pin_n = 1'b0;
        for (int i = 0; i < MINP + 5; i++) begin
            @(negedge clk);
            if (hold) seen_hold = 1;
            if (sclr && stclr && imask && !bstart && !fgo) seen_clr = 1;
        end
        chk(seen_hold, "R5", "long pin pulse enters reset", seen_hold, 1);
        chk(seen_clr, "R1", "clear outputs during pin reset", seen_clr, 1);
        pin_n = 1'b1;
        wait_release(rel);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        bit seen;
        cyc(3);
        // R1: power-on reset state
        chk(hold && sclr && imask && stclr && !bstart && !fgo, "R1", "outputs in power-on reset",
            {hold, sclr, imask, stclr, bstart, fgo}, 6'b111100);

        // R2 / R7 / R9: cold release, direct start
        exp_q.push_back(2);
        por_n = 1'b1;
        wait_release(n);
        chk(n >= LOCK && n <= LOCK + 4, "R2", "cold hold cycles", n, LOCK);
        cyc(2);
        chk(!hold && !imask && !sclr, "R9", "running after release", hold, 0);

        // R4: short pulse ignored
        pin_pulse(MINP - 1);
        seen = 0;
        for (int i = 0; i < MINP + 6; i++) begin
            @(negedge clk);
            if (hold) seen = 1;
        end
        chk(!seen, "R4", "short pin pulse ignored", seen, 0);

        // R3 / R5: warm reset, direct start, no lock wait
        exp_q.push_back(2);
        warm_reset(n);
        chk(n <= 5, "R3", "warm release cycles", n, 3);

        // R5: exactly MIN_PULSE accepted
        exp_q.push_back(2);
        pin_pulse(MINP);
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (hold) seen = 1;
        end
        chk(seen, "R5", "threshold pulse accepted", seen, 1);
        cyc(4);
        chk(!hold, "R3", "running after threshold pulse", hold, 0);

        // R6: boot path
        strap = 1'b0;
        exp_q.push_back(1);
        warm_reset(n);
        cyc(10);
        chk(hold, "R6", "held while booting", hold, 1);
        exp_q.push_back(2);
        bdone = 1'b1; cyc(1); bdone = 1'b0;
        cyc(1);
        chk(!hold, "R6", "released after boot done", hold, 0);

        // R8: bus request at release, strap changes while held -> direct start
        breq = 1'b1;
        warm_reset(n);
        chk(hold, "R8", "held while bus request pending", hold, 1);
        cyc(20);
        chk(hold && !bstart && !fgo, "R8", "still held with bus request", hold, 1);
        strap = 1'b1;
        exp_q.push_back(2);
        breq = 1'b0;
        cyc(4);
        chk(!hold, "R8", "direct start after request drops", hold, 0);

        // R8: bus request then boot
        strap = 1'b0;
        breq = 1'b1;
        warm_reset(n);
        cyc(5);
        exp_q.push_back(1);
        breq = 1'b0;
        cyc(6);
        chk(hold, "R8", "boot after request drops holds core", hold, 1);
        exp_q.push_back(2);
        bdone = 1'b1; cyc(1); bdone = 1'b0;
        cyc(2);
        strap = 1'b1;

        // R3: power-on again re-arms the lock wait
        por_n = 1'b0;
        cyc(3);
        chk(hold && sclr, "R1", "second power-on reset state", hold, 1);
        exp_q.push_back(2);
        por_n = 1'b1;
        wait_release(n);
        chk(n >= LOCK, "R3", "power-on re-arms lock wait", n, LOCK);
        cyc(4);

        chk(exp_q.size() == 0, "R9", "all expected start pulses seen", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule